// File: doc/BRIEF.md
# Periodic Fault Monitor with Latched Error Flags

This block watches four fault conditions: an over-temperature comparator, a supply-low comparator, and one short detector on each of the two speaker output pins. It does not watch them continuously. A millisecond timebase tick drives an interval counter, and the inputs are sampled only when that counter wraps. The sampling period is chosen by a 3-bit code held in a small configuration register. Every fault found at a sample is latched into an error register. A single error output is the registered OR of all the latched bits.

The over-temperature input is filtered. It raises its error only on the second consecutive over-limit sample. An enable bit can switch temperature detection off entirely. A clear pulse empties the error register. The supply-low flag is the exception: it survives a clear for as long as the supply is still low.

A byte-wide read port returns one of two views, chosen by a select input. One view is the error register. The other is a status byte made of per-channel busy and ready flags.

Top module: `fault_monitor`

## Requirements
- R1: After reset, every error bit and `err_out` are 0, the interval code is 001 and temperature detection is enabled.
- R2: Interval code 0 samples the inputs on every clock cycle. A code k from 1 to 6 samples once every 2^k ticks of `ms_tick`. An input that is present only between samples latches nothing.
- R3: Interval code 7 samples once every 128 ticks of `ms_tick`.
- R4: The temperature error (error bit 1) is set only when over-temperature is seen at two consecutive samples. Any in-limit sample restarts the count.
- R5: While the temperature-enable bit is 0, `over_temp` never sets error bit 1, and the consecutive-sample count restarts.
- R6: A short seen at a single sample sets its own error bit: bit 2 for the negative pin and bit 3 for the positive pin.
- R7: A supply-low condition seen at a sample sets error bit 0.
- R8: Latched bits hold until `err_clear`. A clear empties the register, but a fault sampled in the same cycle as the clear is still latched.
- R9: On `err_clear`, bit 0 stays set while `supply_low` is still 1.
- R10: `err_out` is a register equal to the OR of the error bits, and it changes on the same edge as those bits.
- R11: With `rd_sel`=1, `rd_data` is {4'b0, error bits[3:0]}. With `rd_sel`=0, it is {`ch_busy`[3:0], `ch_ready`[3:0]}.
- R12: A configuration write restarts the interval count from zero, so the next sample comes a full period after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle millisecond timebase pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_interval | input | 3 | Sampling interval code |
| cfg_temp_en | input | 1 | Temperature detection enable |
| over_temp | input | 1 | Over-temperature comparator |
| supply_low | input | 1 | Supply-low comparator |
| spk_neg_short | input | 1 | Negative speaker pin short detector |
| spk_pos_short | input | 1 | Positive speaker pin short detector |
| err_clear | input | 1 | Error clear pulse |
| rd_sel | input | 1 | Read view select: 1 = errors, 0 = channel status |
| ch_busy | input | 4 | Per-channel busy flags |
| ch_ready | input | 4 | Per-channel ready flags |
| err_out | output | 1 | Registered OR of the error bits |
| rd_data | output | 8 | Read data |

## Verification
The assertions check several properties on every cycle:
- a sample never fires outside a millisecond tick unless the mode is continuous;
- the hit counter stays bounded;
- the temperature bit rises only while detection is enabled;
- latched bits hold, a clear empties the register, and the supply-low bit survives a clear;
- `err_out` tracks the OR of the bits.

Only the bench scenarios can show the exact sampling period of each code, including the 128-tick code 7. They also show that a configuration write restarts the period, that the two-consecutive-sample rule holds on pulse patterns in continuous mode, and that the read port selects between its two views.

// File: rtl/fm_pkg.sv
package fm_pkg;
    localparam int CODE_W = 3;
    localparam int ERR_W  = 4;
    localparam int ERR_UV  = 0;
    localparam int ERR_TMP = 1;
    localparam int ERR_NEG = 2;
    localparam int ERR_POS = 3;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              temp_en;
    } fm_cfg_t;
endpackage

// File: rtl/fm_interval_gen.sv
module fm_interval_gen #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              sample
);
    localparam int CNT_W = (1 << CODE_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ig_st_t;

    ig_st_t st_d, st_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last;

    always_comb begin
        span   = (CNT_W+1)'(1) << code;
        last   = CNT_W'(span - (CNT_W+1)'(1));
        st_d   = st_q;
        sample = 1'b0;
        if (code == '0) begin
            sample     = 1'b1;
            st_d.cnt   = '0;
        end else if (ms_tick) begin
            if (st_q.cnt == last) begin
                sample   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (restart) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a timed sample only comes with a millisecond tick
    assert_sample_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && code != '0) |-> ms_tick);
    // R3: counter never runs past the selected period
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last);
endmodule

// File: rtl/fm_hit_filter.sv
module fm_hit_filter #(
    parameter int HITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic enable,
    input  logic over,
    output logic fire
);
    localparam int CW = $clog2(HITS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } hf_st_t;

    hf_st_t st_d, st_q;
    logic   hit;

    always_comb begin
        st_d = st_q;
        hit  = sample && enable && over;
        fire = hit && (st_q.cnt >= CW'(HITS - 1));
        if (sample) begin
            if (enable && over) st_d.cnt = (st_q.cnt == CW'(HITS)) ? st_q.cnt : st_q.cnt + 1'b1;
            else                st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: consecutive-hit count saturates at its limit
    assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(HITS));
    // R5: a disabled filter restarts its count at the next sample
    assert_disable_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !enable) |=> st_q.cnt == '0);
endmodule

// File: rtl/fault_monitor.sv
module fault_monitor
    import fm_pkg::*;
#(
    parameter int CHANNELS  = 4,
    parameter int TEMP_HITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ms_tick,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_interval,
    input  logic                  cfg_temp_en,
    input  logic                  over_temp,
    input  logic                  supply_low,
    input  logic                  spk_neg_short,
    input  logic                  spk_pos_short,
    input  logic                  err_clear,
    input  logic                  rd_sel,
    input  logic [CHANNELS-1:0]   ch_busy,
    input  logic [CHANNELS-1:0]   ch_ready,
    output logic                  err_out,
    output logic [2*CHANNELS-1:0] rd_data
);
    localparam int RD_W = 2 * CHANNELS;

    typedef struct packed {
        fm_cfg_t          cfg;
        logic [ERR_W-1:0] err;
        logic             out;
    } mon_st_t;

    mon_st_t          st_d, st_q;
    logic             sample;
    logic             temp_fire;
    logic [ERR_W-1:0] set_v;
    logic [ERR_W-1:0] keep_v;

    fm_interval_gen #(.CODE_W(CODE_W)) u_ivl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .restart (cfg_we),
        .code    (st_q.cfg.code),
        .sample  (sample)
    );

    fm_hit_filter #(.HITS(TEMP_HITS)) u_tmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample),
        .enable (st_q.cfg.temp_en),
        .over   (over_temp),
        .fire   (temp_fire)
    );

    always_comb begin
        st_d  = st_q;
        set_v = '0;
        if (cfg_we) begin
            st_d.cfg.code    = cfg_interval;
            st_d.cfg.temp_en = cfg_temp_en;
        end
        if (sample) begin
            set_v[ERR_UV]  = supply_low;
            set_v[ERR_TMP] = temp_fire;
            set_v[ERR_NEG] = spk_neg_short;
            set_v[ERR_POS] = spk_pos_short;
        end
        keep_v = '1;
        if (err_clear) begin
            keep_v         = '0;
            keep_v[ERR_UV] = supply_low;
        end
        st_d.err = (st_q.err & keep_v) | set_v;
        st_d.out = |st_d.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg.code    <= CODE_W'(1);
            st_q.cfg.temp_en <= 1'b1;
            st_q.err         <= '0;
            st_q.out         <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_out = st_q.out;
    assign rd_data = rd_sel ? RD_W'(st_q.err) : {ch_busy, ch_ready};

    // R5: temperature bit rises only while detection was enabled
    assert_temp_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err[ERR_TMP]) |-> $past(st_q.cfg.temp_en));
    // R8: clear with no sample and a good supply empties the register
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !supply_low && !sample) |=> st_q.err == '0);
    // R8: a latched short holds until cleared
    assert_short_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err[ERR_NEG] && !err_clear) |=> st_q.err[ERR_NEG]);
    // R9: supply-low bit survives a clear while the supply is still low
    assert_uv_persists_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err[ERR_UV] && err_clear && supply_low) |=> st_q.err[ERR_UV]);
    // R10: error output follows the latched bits
    assert_out_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_out == (|st_q.err));
endmodule

// File: tb/sim_fault_monitor.sv
module sim_fault_monitor;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0, ms_tick = 1'b0, cfg_we = 1'b0, cfg_temp_en = 1'b1;
    logic [2:0] cfg_interval = 3'd1;
    logic       over_temp = 0, supply_low = 0, spk_neg_short = 0, spk_pos_short = 0;
    logic       err_clear = 0, rd_sel = 1;
    logic [3:0] ch_busy = 0, ch_ready = 0;
    logic       err_out;
    logic [7:0] rd_data;

    fault_monitor u0 (.*);

    int    n_chk = 0, n_bad = 0, wd = 0, tdiv = 0;
    string cur_req = "R1";
    bit    done = 0;

    // behavioural reference state
    int m_cnt, m_hits, m_code, m_ten;
    bit [3:0] m_err;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        ms_tick = (tdiv == 0);
    end

    always @(posedge clk) begin
        int  period;
        bit  smp;
        bit [3:0] s;
        bit [3:0] keep;
        if (!rst_n) begin
            m_cnt = 0; m_hits = 0; m_code = 1; m_ten = 1; m_err = 0;
        end else begin
            period = 1 << m_code;
            smp = (m_code == 0) || (ms_tick && m_cnt == period - 1);
            s = 0;
            if (smp) begin
                s[0] = supply_low;
                s[2] = spk_neg_short;
                s[3] = spk_pos_short;
                if (m_ten && over_temp) begin
                    s[1] = (m_hits >= 1);
                    m_hits = (m_hits >= 2) ? 2 : m_hits + 1;
                end else m_hits = 0;
            end
            if (m_code != 0 && ms_tick) m_cnt = (m_cnt == period - 1) ? 0 : m_cnt + 1;
            if (m_code == 0) m_cnt = 0;
            keep = err_clear ? {3'b000, supply_low} : 4'hF;
            m_err = (m_err & keep) | s;
            if (cfg_we) begin
                m_cnt = 0; m_code = cfg_interval; m_ten = cfg_temp_en;
            end
        end
    end

    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            chk({cur_req, " out"}, {7'b0, err_out}, {7'b0, (m_err != 0)});
            chk({cur_req, " rd"}, rd_data, rd_sel ? {4'b0, m_err} : {ch_busy, ch_ready});
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp=<150000", wd);
            finish_run();
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(string req, logic [7:0] exp);
        #2;
        chk(req, rd_data, exp);
    endtask

    task automatic clr();
        err_clear = 1; cyc(1); err_clear = 0;
    endtask

    task automatic cfg(logic [2:0] c, logic t);
        cfg_interval = c; cfg_temp_en = t; cfg_we = 1; cyc(1); cfg_we = 0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        cur_req = "R1";
        peek("R1 reset bits", 8'h00);
        chk("R1 reset out", {7'b0, err_out}, 8'h00);

        cur_req = "R7";
        supply_low = 1; cyc(20);
        peek("R7 uv latched", 8'h01);
        chk("R10 out high", {7'b0, err_out}, 8'h01);

        cur_req = "R9";
        clr(); cyc(1);
        peek("R9 uv survives clear", 8'h01);
        supply_low = 0; cyc(1);
        cur_req = "R8";
        clr(); cyc(1);
        peek("R8 cleared", 8'h00);

        cur_req = "R4";
        cfg(3'd0, 1'b1);
        over_temp = 1; cyc(1); over_temp = 0; cyc(1); over_temp = 1; cyc(1); over_temp = 0; cyc(2);
        peek("R4 non-consecutive", 8'h00);
        over_temp = 1; cyc(2); over_temp = 0; cyc(1);
        peek("R4 two hits", 8'h02);
        clr(); cyc(1);

        cur_req = "R2";
        supply_low = 1; cyc(1); supply_low = 0; cyc(1);
        peek("R2 continuous pulse", 8'h01);
        clr(); cyc(1);

        cur_req = "R12";
        cfg(3'd2, 1'b1);
        supply_low = 1; cyc(10); supply_low = 0; cyc(1);
        peek("R12 no sample before full period", 8'h00);
        cyc(40);

        cur_req = "R4";
        cfg(3'd1, 1'b1);
        over_temp = 1; cyc(24); over_temp = 0; cyc(1);
        peek("R4 timed two hits", 8'h02);
        clr(); cyc(1);

        cur_req = "R5";
        cfg(3'd1, 1'b0);
        over_temp = 1; cyc(40); over_temp = 0; cyc(1);
        peek("R5 disabled", 8'h00);
        cfg(3'd1, 1'b1);

        cur_req = "R6";
        spk_neg_short = 1; cyc(12); spk_neg_short = 0; cyc(1);
        peek("R6 neg short", 8'h04);
        spk_pos_short = 1; cyc(12); spk_pos_short = 0; cyc(1);
        peek("R6 both shorts", 8'h0C);
        cur_req = "R8";
        cyc(30);
        peek("R8 shorts held", 8'h0C);
        clr(); cyc(1);

        cur_req = "R11";
        ch_busy = 4'hA; ch_ready = 4'h5; rd_sel = 0;
        peek("R11 status view", 8'hA5);
        rd_sel = 1;

        cur_req = "R3";
        cfg(3'd7, 1'b1);
        supply_low = 1; cyc(400);
        peek("R3 not yet sampled", 8'h00);
        cyc(200);
        peek("R3 sampled at 128 ticks", 8'h01);
        supply_low = 0; cyc(2); clr(); cyc(2);
        peek("R8 final clear", 8'h00);

        finish_run();
    end
endmodule